// File: doc/BRIEF.md
# E1 Signalling Multiframe Aligner and ABCD Mapper

This block handles time slot 16 of an E1 stream that is already frame aligned. On the receive side it takes one time slot 16 octet per basic frame, qualified by a strobe. It hunts for the signalling multiframe alignment nibble and reports whether it holds alignment, along with the number of the next expected frame in the 16-frame multiframe. While aligned, it stores the two ABCD signalling nibbles that each of frames 1 to 15 carries in a 30-entry receive table. A combinational read port exposes that table.

On the transmit side a second 30-entry table holds the outgoing ABCD nibble for each channel, and a write port fills it. A free-running transmit frame counter steps on every outgoing frame strobe. The block always presents the time slot 16 octet for the current transmit frame. Frame 0 carries the alignment nibble, the spare bits and a remote alarm bit that reflects the local receive alignment. Frames 1 to 15 carry two channel nibbles each. The receive and transmit frame counters are independent of each other and of any CRC-4 timing.

Bit 1 of an octet is its most significant bit (`[7]`) and is sent first. "Upper nibble" means bits `[7:4]`.

Top module: `e1sig_cas_mframe`

## Requirements
- R1: After reset the receiver is unaligned and `rx_frame_num` is 0. `tx_frame_num` is 0. Every transmit table entry is 1101, so the first frame 1 octet is 8'hDD. A read of any receive table entry returns 1101.
- R2: While unaligned, a received octet with upper nibble 0000 declares alignment only if the previously received octet was not 8'h00. The octet that declares alignment is frame 0, so `rx_frame_num` reads 1 on the next cycle. After reset there is no previous octet, and it counts as all-zero.
- R3: Each `rx_valid` advances `rx_frame_num` by one modulo 16, except when an octet declares alignment. Without `rx_valid`, `rx_frame_num` and `rx_locked` keep their values.
- R4: While aligned, a frame 0 octet whose upper nibble is not 0000 is an error. The second consecutive such error drops alignment. A correct frame 0 octet clears the error count.
- R5: While aligned, the 16th consecutive received octet equal to 8'h00 drops alignment.
- R6: While aligned, the octet of frame n (1..15) stores its upper nibble as channel n and its lower nibble as channel n+15. `rd_abcd` returns channel `rd_chan` (1..30). For a channel number outside 1..30 it returns 1101.
- R7: Octets received while unaligned, and frame 0 octets, leave the receive table unchanged.
- R8: The transmit frame 0 octet is 0000 in `[7:4]`, has spare bits in `[3]`, `[1]` and `[0]` taken from parameter X_BITS (default 1), and has `[2]` = 0 when `rx_locked` is high and 1 when it is low.
- R9: The transmit octet of frame n (1..15) is {table[n], table[n+15]}.
- R10: Each `tx_strobe` advances `tx_frame_num` by one modulo 16. A `tx_wr_en` write to a channel outside 1..30 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received time slot 16 octet is present |
| rx_ts16 | input | 8 | Received time slot 16 octet |
| rx_locked | output | 1 | Receive multiframe alignment held |
| rx_frame_num | output | 4 | Number of the next expected receive frame |
| rd_chan | input | 5 | Channel to read from the receive table |
| rd_abcd | output | 4 | Stored ABCD nibble of `rd_chan` |
| tx_wr_en | input | 1 | Write strobe for the transmit table |
| tx_wr_chan | input | 5 | Channel to write (1..30) |
| tx_wr_abcd | input | 4 | ABCD nibble to write |
| tx_strobe | input | 1 | Current transmit octet consumed; advance frame |
| tx_frame_num | output | 4 | Current transmit frame number |
| tx_ts16 | output | 8 | Time slot 16 octet for the current transmit frame |

## Verification
Assertions check these properties on every cycle:
- both frame counters step by exactly one per strobe and hold otherwise;
- alignment only rises on a zero-nibble octet and leaves the counter at 1;
- alignment only falls on a received octet;
- the receive table does not move while unaligned;
- the transmitted Y bit matches the alignment flag.

The bench scenarios are needed for the rest:
- the preceding-octet condition on acquisition;
- tolerance of a single bad alignment nibble;
- the 16-zero loss rule;
- the channel n / n+15 mapping in both directions;
- rejection of out-of-range channel writes.

Random multiframes with injected nibble errors and frame slips exercise the hunt and loss paths against a reference model.

// File: rtl/e1sig_pkg.sv
package e1sig_pkg;
   localparam logic [3:0] ABCD_IDLE  = 4'b1101;
   localparam logic [3:0] MFA_NIBBLE = 4'b0000;
   typedef enum logic {AL_HUNT = 1'b0, AL_LOCK = 1'b1} align_state_t;
endpackage

// File: rtl/e1sig_rx_align.sv
module e1sig_rx_align
   import e1sig_pkg::*;
#(
   parameter int unsigned NUM_FRAMES = 16,
   parameter int unsigned ERR_LIMIT  = 2,
   parameter int unsigned ZERO_LIMIT = 16,
   localparam int unsigned FN_W = $clog2(NUM_FRAMES),
   localparam int unsigned EC_W = $clog2(ERR_LIMIT + 1),
   localparam int unsigned ZC_W = $clog2(ZERO_LIMIT + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid,
   input  logic [7:0]      octet,
   output logic            locked,
   output logic [FN_W-1:0] frame_num,
   output logic            store_en
);
   if ((1 << FN_W) != NUM_FRAMES || NUM_FRAMES < 4) begin : g_bad_frames
      $error("NUM_FRAMES must be a power of two of at least 4");
   end
   if (ERR_LIMIT < 1 || ZERO_LIMIT < 2) begin : g_bad_limits
      $error("ERR_LIMIT must be >= 1 and ZERO_LIMIT >= 2");
   end

   align_state_t    st_q;
   logic [FN_W-1:0] fn_q;
   logic [EC_W-1:0] err_q;
   logic [ZC_W-1:0] zc_q;
   logic            prev_nz_q;

   logic mfa_seen, all_zero, at_f0, detect, bad_f0, err_lost, zero_lost;

   always_comb begin
      mfa_seen  = (octet[7:4] == MFA_NIBBLE);
      all_zero  = (octet == 8'h00);
      at_f0     = (fn_q == '0);
      detect    = valid && (st_q == AL_HUNT) && mfa_seen && prev_nz_q;
      bad_f0    = valid && (st_q == AL_LOCK) && at_f0 && !mfa_seen;
      err_lost  = bad_f0 && (err_q == EC_W'(ERR_LIMIT - 1));
      zero_lost = valid && (st_q == AL_LOCK) && all_zero &&
                  (zc_q == ZC_W'(ZERO_LIMIT - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= AL_HUNT;
         fn_q      <= '0;
         err_q     <= '0;
         zc_q      <= '0;
         prev_nz_q <= 1'b0;
      end else if (valid) begin
         prev_nz_q <= !all_zero;
         if (!all_zero)                    zc_q <= '0;
         else if (zc_q != ZC_W'(ZERO_LIMIT)) zc_q <= zc_q + ZC_W'(1);
         if (detect) begin
            st_q  <= AL_LOCK;
            fn_q  <= FN_W'(1);
            err_q <= '0;
         end else begin
            fn_q <= fn_q + FN_W'(1);
            if (err_lost || zero_lost) begin
               st_q  <= AL_HUNT;
               err_q <= '0;
            end else if (st_q == AL_LOCK && at_f0) begin
               err_q <= mfa_seen ? '0 : err_q + EC_W'(1);
            end
         end
      end
   end

   assign locked    = (st_q == AL_LOCK);
   assign frame_num = fn_q;
   assign store_en  = valid && (st_q == AL_LOCK) && !at_f0;

   // R3
   fn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !detect |=> fn_q == $past(fn_q) + FN_W'(1));
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> $stable(fn_q) && $stable(st_q));
   // R2
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> fn_q == FN_W'(1) && $past(valid) && $past(octet[7:4]) == MFA_NIBBLE);
   // R4
   lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(valid));
endmodule

// File: rtl/e1sig_abcd_store.sv
module e1sig_abcd_store #(
   parameter int unsigned NUM_CH  = 30,
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned DW      = 4,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wa_en,
   input  logic [IDX_W-1:0] wa_idx,
   input  logic [DW-1:0]    wa_dat,
   input  logic             wb_en,
   input  logic [IDX_W-1:0] wb_idx,
   input  logic [DW-1:0]    wb_dat,
   input  logic [IDX_W-1:0] ra_idx,
   output logic [DW-1:0]    ra_dat,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [DW-1:0]    rb_dat
);
   if (NUM_CH < 1 || NUM_CH >= (1 << IDX_W)) begin : g_bad_depth
      $error("NUM_CH must fit below 2**IDX_W");
   end

   logic [NUM_CH-1:0][DW-1:0] ent_vec;

   for (genvar e = 0; e < NUM_CH; e++) begin : g_ent
      logic [DW-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                ent_q <= RST_VAL;
         else if (wb_en && wb_idx == IDX_W'(e))     ent_q <= wb_dat;
         else if (wa_en && wa_idx == IDX_W'(e))     ent_q <= wa_dat;
      end
      assign ent_vec[e] = ent_q;
   end

   always_comb begin
      ra_dat = RST_VAL;
      rb_dat = RST_VAL;
      for (int e = 0; e < NUM_CH; e++) begin
         if (ra_idx == IDX_W'(e)) ra_dat = ent_vec[e];
         if (rb_idx == IDX_W'(e)) rb_dat = ent_vec[e];
      end
   end
endmodule

// File: rtl/e1sig_tx_build.sv
module e1sig_tx_build
   import e1sig_pkg::*;
#(
   parameter int unsigned NUM_FRAMES = 16,
   parameter logic [2:0]  X_BITS     = 3'b111,
   localparam int unsigned FN_W = $clog2(NUM_FRAMES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strobe,
   input  logic            locked,
   input  logic [3:0]      abcd_hi,
   input  logic [3:0]      abcd_lo,
   output logic [FN_W-1:0] frame_num,
   output logic [7:0]      octet
);
   if ((1 << FN_W) != NUM_FRAMES) begin : g_bad_frames
      $error("NUM_FRAMES must be a power of two");
   end

   logic [FN_W-1:0] fn_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      fn_q <= '0;
      else if (strobe) fn_q <= fn_q + FN_W'(1);
   end

   always_comb begin
      if (fn_q == '0) octet = {MFA_NIBBLE, X_BITS[2], ~locked, X_BITS[1:0]};
      else            octet = {abcd_hi, abcd_lo};
   end

   assign frame_num = fn_q;

   // R10
   tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> fn_q == $past(fn_q) + FN_W'(1));
   // R10
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(fn_q));
endmodule

// File: rtl/e1sig_cas_mframe.sv
module e1sig_cas_mframe
   import e1sig_pkg::*;
#(
   parameter int unsigned NUM_FRAMES = 16,
   parameter int unsigned ERR_LIMIT  = 2,
   parameter logic [2:0]  X_BITS     = 3'b111,
   localparam int unsigned FN_W   = $clog2(NUM_FRAMES),
   localparam int unsigned NUM_CH = 2 * (NUM_FRAMES - 1),
   localparam int unsigned CH_W   = $clog2(NUM_CH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_valid,
   input  logic [7:0]      rx_ts16,
   output logic            rx_locked,
   output logic [FN_W-1:0] rx_frame_num,
   input  logic [CH_W-1:0] rd_chan,
   output logic [3:0]      rd_abcd,
   input  logic            tx_wr_en,
   input  logic [CH_W-1:0] tx_wr_chan,
   input  logic [3:0]      tx_wr_abcd,
   input  logic            tx_strobe,
   output logic [FN_W-1:0] tx_frame_num,
   output logic [7:0]      tx_ts16
);
   localparam logic [CH_W-1:0] HI_OFS = CH_W'(1);
   localparam logic [CH_W-1:0] LO_OFS = CH_W'(NUM_FRAMES - 2);

   logic            rx_store;
   logic [CH_W-1:0] rx_hi_idx, rx_lo_idx, tx_hi_idx, tx_lo_idx;
   logic [3:0]      tx_hi, tx_lo, rx_unused;

   e1sig_rx_align #(
      .NUM_FRAMES(NUM_FRAMES), .ERR_LIMIT(ERR_LIMIT), .ZERO_LIMIT(NUM_FRAMES)
   ) align_i (
      .clk(clk), .rst_n(rst_n), .valid(rx_valid), .octet(rx_ts16),
      .locked(rx_locked), .frame_num(rx_frame_num), .store_en(rx_store)
   );

   // frame n maps to table index n-1 (upper) and n+NUM_FRAMES-2 (lower)
   assign rx_hi_idx = CH_W'(rx_frame_num) - HI_OFS;
   assign rx_lo_idx = CH_W'(rx_frame_num) + LO_OFS;
   assign tx_hi_idx = CH_W'(tx_frame_num) - HI_OFS;
   assign tx_lo_idx = CH_W'(tx_frame_num) + LO_OFS;

   e1sig_abcd_store #(
      .NUM_CH(NUM_CH), .IDX_W(CH_W), .DW(4), .RST_VAL(ABCD_IDLE)
   ) rx_tab_i (
      .clk(clk), .rst_n(rst_n),
      .wa_en(rx_store), .wa_idx(rx_hi_idx), .wa_dat(rx_ts16[7:4]),
      .wb_en(rx_store), .wb_idx(rx_lo_idx), .wb_dat(rx_ts16[3:0]),
      .ra_idx(rd_chan - HI_OFS), .ra_dat(rd_abcd),
      .rb_idx('0), .rb_dat(rx_unused)
   );

   e1sig_abcd_store #(
      .NUM_CH(NUM_CH), .IDX_W(CH_W), .DW(4), .RST_VAL(ABCD_IDLE)
   ) tx_tab_i (
      .clk(clk), .rst_n(rst_n),
      .wa_en(tx_wr_en), .wa_idx(tx_wr_chan - HI_OFS), .wa_dat(tx_wr_abcd),
      .wb_en(1'b0), .wb_idx('0), .wb_dat(4'h0),
      .ra_idx(tx_hi_idx), .ra_dat(tx_hi),
      .rb_idx(tx_lo_idx), .rb_dat(tx_lo)
   );

   e1sig_tx_build #(
      .NUM_FRAMES(NUM_FRAMES), .X_BITS(X_BITS)
   ) tx_i (
      .clk(clk), .rst_n(rst_n), .strobe(tx_strobe), .locked(rx_locked),
      .abcd_hi(tx_hi), .abcd_lo(tx_lo),
      .frame_num(tx_frame_num), .octet(tx_ts16)
   );

   // R8
   y_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_frame_num == '0 |-> tx_ts16[2] == !rx_locked && tx_ts16[7:4] == MFA_NIBBLE);
   // R7
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_locked |=> $stable(rd_abcd) || !$stable(rd_chan));
endmodule

// File: tb/e1sig_cas_mframe_tb_top.sv
module e1sig_cas_mframe_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NF  = 16;
   localparam int NCH = 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0;
   logic [7:0] rx_ts16 = 8'h00;
   logic rx_locked;
   logic [3:0] rx_frame_num;
   logic [4:0] rd_chan = 5'd1;
   logic [3:0] rd_abcd;
   logic tx_wr_en = 1'b0;
   logic [4:0] tx_wr_chan = 5'd0;
   logic [3:0] tx_wr_abcd = 4'h0;
   logic tx_strobe = 1'b0;
   logic [3:0] tx_frame_num;
   logic [7:0] tx_ts16;

   always #(CLK_PERIOD / 2) clk = ~clk;

   e1sig_cas_mframe dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ts16(rx_ts16),
      .rx_locked(rx_locked), .rx_frame_num(rx_frame_num),
      .rd_chan(rd_chan), .rd_abcd(rd_abcd),
      .tx_wr_en(tx_wr_en), .tx_wr_chan(tx_wr_chan), .tx_wr_abcd(tx_wr_abcd),
      .tx_strobe(tx_strobe), .tx_frame_num(tx_frame_num), .tx_ts16(tx_ts16)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model
   bit m_lock, m_prevnz;
   int m_fn, m_err, m_zc, m_tfn;
   logic [3:0] m_rx [NCH];
   logic [3:0] m_tx [NCH];

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_tx();
      if (m_tfn == 0) return {4'h0, 1'b1, !m_lock, 2'b11};
      return {m_tx[m_tfn - 1], m_tx[m_tfn + NF - 2]};
   endfunction

   function automatic void model_rx(logic [7:0] o);
      bit lose = 1'b0;
      if (!m_lock) begin
         if (o[7:4] == 4'h0 && m_prevnz) begin
            m_lock = 1'b1; m_fn = 1; m_err = 0;
         end else m_fn = (m_fn + 1) % NF;
      end else begin
         if (m_fn != 0) begin
            m_rx[m_fn - 1] = o[7:4];
            m_rx[m_fn + NF - 2] = o[3:0];
         end else if (o[7:4] != 4'h0) begin
            if (m_err == 1) lose = 1'b1; else m_err = 1;
         end else m_err = 0;
         if (o == 8'h00 && m_zc == NF - 1) lose = 1'b1;
         if (lose) begin m_lock = 1'b0; m_err = 0; end
         m_fn = (m_fn + 1) % NF;
      end
      if (o != 8'h00) m_zc = 0; else if (m_zc < NF) m_zc++;
      m_prevnz = (o != 8'h00);
   endfunction

   task automatic tx_check(string req);
      chk(req, "tx octet", tx_ts16, exp_tx());
      chk(req, "tx frame", tx_frame_num, m_tfn);
   endtask

   task automatic rx_push(logic [7:0] o, string req);
      rx_valid = 1'b1; rx_ts16 = o;
      @(negedge clk);
      rx_valid = 1'b0;
      model_rx(o);
      chk(req, "locked", rx_locked, m_lock);
      chk(req, "rx frame", rx_frame_num, m_fn);
   endtask

   task automatic tx_step(string req);
      tx_strobe = 1'b1;
      @(negedge clk);
      tx_strobe = 1'b0;
      m_tfn = (m_tfn + 1) % NF;
      tx_check(req);
   endtask

   task automatic tx_write(int ch, logic [3:0] v);
      tx_wr_en = 1'b1; tx_wr_chan = 5'(ch); tx_wr_abcd = v;
      @(negedge clk);
      tx_wr_en = 1'b0;
      if (ch >= 1 && ch <= NCH) m_tx[ch - 1] = v;
   endtask

   task automatic check_rd(string req);
      for (int ch = 1; ch <= NCH; ch++) begin
         rd_chan = 5'(ch); #1;
         chk(req, "rd abcd", rd_abcd, m_rx[ch - 1]);
      end
      rd_chan = 5'd0; #1;
      chk(req, "rd chan 0", rd_abcd, 4'b1101);
      rd_chan = 5'd31; #1;
      chk(req, "rd chan 31", rd_abcd, 4'b1101);
      @(negedge clk);
   endtask

   task automatic send_mf(logic [7:0] f0, bit rnd, string req);
      rx_push(f0, req);
      for (int n = 1; n < NF; n++) begin
         if (rnd) rx_push(8'($urandom), req);
         else     rx_push({4'(n), ~4'(n)}, req);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0E11));
      m_lock = 0; m_prevnz = 0; m_fn = 0; m_err = 0; m_zc = 0; m_tfn = 0;
      for (int i = 0; i < NCH; i++) begin m_rx[i] = 4'b1101; m_tx[i] = 4'b1101; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "locked", rx_locked, 0);
      chk("R1", "rx frame", rx_frame_num, 0);
      chk("R1", "tx frame", tx_frame_num, 0);
      chk("R8", "tx f0 unlocked", tx_ts16, 8'h0F);
      check_rd("R1");
      tx_step("R1");
      chk("R1", "idle f1 octet", tx_ts16, 8'hDD);
      for (int i = 2; i <= NF; i++) tx_step("R10");
      chk("R10", "tx wrap", tx_frame_num, 0);

      // R2 acquisition needs a non-zero preceding octet
      rx_push(8'h00, "R2");
      rx_push(8'h0B, "R2");
      chk("R2", "no lock after zero", rx_locked, 0);
      rx_push(8'h5A, "R2");
      rx_push(8'h0B, "R2");
      chk("R2", "lock", rx_locked, 1);
      chk("R2", "frame after lock", rx_frame_num, 1);
      tx_check("R8");
      for (int n = 1; n < NF; n++) rx_push({4'(n), ~4'(n)}, "R6");
      check_rd("R6");

      // R4 single error tolerated, two in a row lose alignment
      send_mf(8'h8B, 1'b0, "R4");
      chk("R4", "one error kept", rx_locked, 1);
      send_mf(8'h0B, 1'b0, "R4");
      send_mf(8'h4B, 1'b0, "R4");
      rx_push(8'hCB, "R4");
      chk("R4", "lost after two", rx_locked, 0);
      tx_check("R8");

      // R7 unaligned octets are not stored
      for (int i = 0; i < 20; i++) rx_push(8'h77, "R7");
      check_rd("R7");

      // R5 sixteen zero octets lose alignment
      rx_push(8'h5A, "R5");
      rx_push(8'h0B, "R5");
      chk("R5", "relock", rx_locked, 1);
      for (int i = 0; i < 15; i++) rx_push(8'h00, "R5");
      chk("R5", "15 zeros kept", rx_locked, 1);
      rx_push(8'h00, "R5");
      chk("R5", "16 zeros lost", rx_locked, 0);
      check_rd("R6");

      // R9 and R10 transmit mapping and out-of-range writes
      tx_write(0, 4'h0);
      tx_write(31, 4'h0);
      tx_write(3, 4'hA);
      tx_write(18, 4'h5);
      for (int i = 0; i < 3; i++) tx_step("R9");
      chk("R9", "frame 3 octet", tx_ts16, 8'hA5);
      for (int i = 3; i < NF; i++) tx_step("R10");
      tx_step("R10");
      chk("R10", "oob write ignored f1", tx_ts16, 8'hDD);

      // random multiframes with faults, interleaved transmit activity
      rx_push(8'h33, "R2");
      for (int mf = 0; mf < 40; mf++) begin
         int sel = int'($urandom % 10);
         if (sel == 0)      send_mf({4'(1 + $urandom % 15), 4'hB}, 1'b1, "R4");
         else if (sel == 1) rx_push(8'($urandom), "R3");
         else               send_mf(8'h0B, 1'b1, "R6");
         for (int k = 0; k < 4; k++) begin
            if ($urandom % 2 == 0) tx_write(int'($urandom % 32), 4'($urandom));
            tx_step("R9");
         end
         tx_check("R8");
         if (mf % 8 == 7) check_rd("R6");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule